// File: doc/BRIEF.md
# Deep Low-Power Entry and Wake Controller

This block sits in the always-on power domain of a platform that is already in hibernate or soft-off. It decides when the platform may go one step lower, into a state where the primary power wells are switched off and only a small always-on domain stays alive. Entry first needs a compound qualification: an enable bit, the management subsystem being off, a sleep state that qualifies, a policy bit chosen by state and power source, and two optional gating conditions.

Once the platform qualifies, the controller lowers an active-low warning output. It waits until the board acknowledges by holding an active-low acknowledge input low for a filtered number of cycles. Only then does it lower the active-low well-off output, which removes primary power.

While deep, only a few wake sources are honoured, each with its own enable. The power button needs no enable. A wake raises the well-off output and then releases the warning. A register records which sources caused the wake. If the policy allows the deep state only on battery, a rising AC-present input raises the wells without counting as a wake. If AC then drops before any wake arrives, the controller goes straight back down.

Top module: `deep_rest_ctrl`

## Requirements
- R1: After reset, `warn_n` and `well_off_n` are 1 and `wake_cause` is 0.
- R2: From idle, `warn_n` falls one cycle after all of these hold together. `cfg_en` is 1. `mgmt_off` is 1. `sleep_st` is 2 (hibernate) or 3 (soft-off). `pol_ok[{sleep_st[0], on_ac}]` is 1. If any of these is false, `warn_n` stays 1.
- R3: When `pol_need_bl` is 1, entry also needs `batt_low` to be 1. When `pol_need_conn` is 1, entry also needs `conn_wake_en` to be 1.
- R4: `well_off_n` falls only after `ack_n` has been 0 for `ACK_FILT` consecutive cycles while warning. A shorter low pulse on `ack_n` restarts the count.
- R5: If the entry condition goes false while warning, `warn_n` returns to 1 on the next cycle and `well_off_n` stays 1.
- R6: While deep, a wake source raises `well_off_n` on the next cycle. `wake_req` and `wake_en` use this bit order: bit 0 RTC alarm, bit 1 power button, bit 2 PCIe wake, bit 3 LAN wake, bit 4 wake-alarm device. A source counts when its request bit is 1 and its enable bit is 1. The power button counts whatever its enable bit says.
- R7: While deep, a request whose enable is 0 leaves `well_off_n` at 0.
- R8: While deep, a rise of `on_ac` raises `well_off_n` and keeps `warn_n` at 0, but only when `pol_ok[1]` and `pol_ok[3]` are both 0 (deep state allowed on battery only). With any other policy, the rise has no effect.
- R9: In the AC-raised state with no wake pending, a fall of `on_ac` lowers `well_off_n` again on the next cycle.
- R10: While deep, a rise of `on_ac` with `ac_wake_en` = 1 counts as a wake and sets `wake_cause[5]`.
- R11: On a wake exit, `wake_cause[4:0]` captures the counted sources, in the same bit order as `wake_req`. `warn_n` returns to 1 one cycle after `well_off_n` rises. `wake_cause` clears when `well_off_n` next falls.
- R12: After a wake exit, there is no new entry until the entry condition has been false for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Deep state permitted |
| sleep_st | input | 2 | Current sleep state; 2 is hibernate, 3 is soft-off |
| mgmt_off | input | 1 | Management subsystem is off |
| on_ac | input | 1 | AC power present |
| batt_low | input | 1 | Battery low indication |
| pol_ok | input | 4 | Policy bits indexed by {sleep_st[0], on_ac} |
| pol_need_bl | input | 1 | Entry gated by battery low |
| pol_need_conn | input | 1 | Entry gated by connectivity wake enable |
| conn_wake_en | input | 1 | Connectivity wake is enabled |
| wake_req | input | 5 | Wake requests: RTC, button, PCIe, LAN, alarm device |
| wake_en | input | 5 | Per-source wake enables; the button bit is ignored |
| ac_wake_en | input | 1 | AC-present rise counts as a wake |
| ack_n | input | 1 | Active-low acknowledge of the warning |
| warn_n | output | 1 | Active-low warning that the deep state is near |
| well_off_n | output | 1 | Active-low primary-well power-off request |
| wake_cause | output | 6 | Captured wake sources; bit 5 is AC |

## Verification
The assertions check several orderings on every cycle. The wells are never cut without a preceding acknowledge. An abort happens only when entry has been lost. A counted wake while deep always raises the wells, and every exit carries a nonzero cause. An AC drop in the AC-raised state restores the deep state. The warning is only released while the wells are up. Only the bench's scenarios can show other behaviours: the exact entry truth table, which is swept over every combination of the qualifier inputs; the restart of the acknowledge filter after a short pulse; the re-arm rule after a wake; and the exact cause encoding for each source.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WARN = 3'd1,
    ST_DEEP = 3'd2,
    ST_ACUP = 3'd3,
    ST_EXIT = 3'd4
  } drc_state_e;

  localparam int REQ_N  = 5;
  localparam int SRC_N  = REQ_N + 1;
  localparam int BTN_IX = 1;
  localparam int AC_IX  = 5;
  localparam int POL_W  = 4;
endpackage

// File: rtl/drc_entry_qual.sv
module drc_entry_qual
  import drc_pkg::*;
(
  input  logic             cfg_en,
  input  logic [1:0]       sleep_st,
  input  logic             mgmt_off,
  input  logic             on_ac,
  input  logic             batt_low,
  input  logic [POL_W-1:0] pol_ok,
  input  logic             pol_need_bl,
  input  logic             pol_need_conn,
  input  logic             conn_wake_en,
  output logic             entry_ok,
  output logic             batt_only
);
  logic [1:0] pol_ix;
  logic       state_ok;
  logic       pol_hit;
  logic       gate_bl;
  logic       gate_conn;

  always_comb begin
    pol_ix    = {sleep_st[0], on_ac};
    state_ok  = sleep_st[1];
    pol_hit   = pol_ok[pol_ix];
    gate_bl   = !pol_need_bl || batt_low;
    gate_conn = !pol_need_conn || conn_wake_en;
    entry_ok  = cfg_en && mgmt_off && state_ok && pol_hit && gate_bl && gate_conn;
    batt_only = !pol_ok[1] && !pol_ok[3];
  end
endmodule

// File: rtl/drc_wake_eval.sv
module drc_wake_eval
  import drc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] wake_req,
  input  logic [REQ_N-1:0] wake_en,
  input  logic             on_ac,
  input  logic             ac_wake_en,
  output logic             ac_rise,
  output logic [SRC_N-1:0] hits
);
  localparam logic [REQ_N-1:0] ALWAYS_ON = REQ_N'(1) << BTN_IX;

  logic ac_q;
  logic [REQ_N-1:0] eff_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac_q <= 1'b0;
    else        ac_q <= on_ac;
  end

  always_comb begin
    ac_rise = on_ac && !ac_q;
    eff_en  = wake_en | ALWAYS_ON;
  end

  for (genvar i = 0; i < REQ_N; i++) begin : g_src
    assign hits[i] = wake_req[i] && eff_en[i];
  end
  assign hits[AC_IX] = ac_rise && ac_wake_en;
endmodule

// File: rtl/drc_seq_fsm.sv
module drc_seq_fsm
  import drc_pkg::*;
#(
  parameter int ACK_FILT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_ok,
  input  logic             batt_only,
  input  logic             on_ac,
  input  logic             ac_rise,
  input  logic [SRC_N-1:0] hits,
  input  logic             ack_n,
  output logic             warn_n,
  output logic             well_off_n,
  output logic [SRC_N-1:0] wake_cause
);
  localparam int CW = $clog2(ACK_FILT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_FILT - 1);

  drc_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic hold_q, hold_d;
  logic [SRC_N-1:0] cause_q, cause_d;
  logic cause_ld;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    cause_d  = cause_q;
    cause_ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!entry_ok)    hold_d = 1'b0;
        else if (!hold_q) st_d = ST_WARN;
      end
      ST_WARN: begin
        if (!entry_ok) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (!ack_n) begin
          if (cnt_q == CNT_LAST) begin
            st_d     = ST_DEEP;
            cnt_d    = '0;
            cause_d  = '0;
            cause_ld = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      ST_DEEP: begin
        if (|hits) begin
          st_d     = ST_EXIT;
          cause_d  = hits;
          cause_ld = 1'b1;
        end else if (ac_rise && batt_only) begin
          st_d = ST_ACUP;
        end
      end
      ST_ACUP: begin
        if (|hits) begin
          st_d     = ST_EXIT;
          cause_d  = hits;
          cause_ld = 1'b1;
        end else if (!on_ac) begin
          st_d = ST_DEEP;
        end
      end
      ST_EXIT: begin
        st_d   = ST_IDLE;
        hold_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_ld) cause_q <= cause_d;
  end

  always_comb begin
    warn_n     = (st_q == ST_IDLE);
    well_off_n = (st_q != ST_DEEP);
    wake_cause = cause_q;
  end

  assert_ack_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEEP && $past(st_q) == ST_WARN) |-> $past(!ack_n));

  assert_abort_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) == ST_WARN) |-> $past(!entry_ok));

  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEEP && |hits) |=> well_off_n);

  assert_ac_reentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACUP && !on_ac && hits == '0) |=> !well_off_n);

  assert_cause_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXIT) |-> (wake_cause != '0));

  assert_warn_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> $past(well_off_n));
endmodule

// File: rtl/deep_rest_ctrl.sv
module deep_rest_ctrl
  import drc_pkg::*;
#(
  parameter int ACK_FILT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic [1:0] sleep_st,
  input  logic       mgmt_off,
  input  logic       on_ac,
  input  logic       batt_low,
  input  logic [3:0] pol_ok,
  input  logic       pol_need_bl,
  input  logic       pol_need_conn,
  input  logic       conn_wake_en,
  input  logic [4:0] wake_req,
  input  logic [4:0] wake_en,
  input  logic       ac_wake_en,
  input  logic       ack_n,
  output logic       warn_n,
  output logic       well_off_n,
  output logic [5:0] wake_cause
);
  logic entry_ok;
  logic batt_only;
  logic ac_rise;
  logic [SRC_N-1:0] hits;

  drc_entry_qual u_qual (
    .cfg_en(cfg_en), .sleep_st(sleep_st), .mgmt_off(mgmt_off), .on_ac(on_ac),
    .batt_low(batt_low), .pol_ok(pol_ok), .pol_need_bl(pol_need_bl),
    .pol_need_conn(pol_need_conn), .conn_wake_en(conn_wake_en),
    .entry_ok(entry_ok), .batt_only(batt_only)
  );

  drc_wake_eval u_wake (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_en(wake_en),
    .on_ac(on_ac), .ac_wake_en(ac_wake_en), .ac_rise(ac_rise), .hits(hits)
  );

  drc_seq_fsm #(.ACK_FILT(ACK_FILT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .batt_only(batt_only),
    .on_ac(on_ac), .ac_rise(ac_rise), .hits(hits), .ack_n(ack_n),
    .warn_n(warn_n), .well_off_n(well_off_n), .wake_cause(wake_cause)
  );

  assert_off_needs_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(well_off_n) |-> (!warn_n && $past(!warn_n)));
endmodule

// File: tb/deep_rest_ctrl_bench.sv
module deep_rest_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 0, mgmt_off = 0, on_ac = 0, batt_low = 0;
  logic pol_need_bl = 0, pol_need_conn = 0, conn_wake_en = 0, ac_wake_en = 0;
  logic ack_n = 1;
  logic [1:0] sleep_st = 0;
  logic [3:0] pol_ok = 0;
  logic [4:0] wake_req = 0, wake_en = 0;
  logic warn_n, well_off_n;
  logic [5:0] wake_cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deep_rest_ctrl u_deep_rest_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .sleep_st(sleep_st),
    .mgmt_off(mgmt_off), .on_ac(on_ac), .batt_low(batt_low), .pol_ok(pol_ok),
    .pol_need_bl(pol_need_bl), .pol_need_conn(pol_need_conn),
    .conn_wake_en(conn_wake_en), .wake_req(wake_req), .wake_en(wake_en),
    .ac_wake_en(ac_wake_en), .ack_n(ack_n), .warn_n(warn_n),
    .well_off_n(well_off_n), .wake_cause(wake_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic good_setup();
    cfg_en = 1; mgmt_off = 1; sleep_st = 2'd3; on_ac = 0; batt_low = 0;
    pol_ok = 4'b0100; pol_need_bl = 0; pol_need_conn = 0; conn_wake_en = 0;
  endtask

  // from idle with a held re-arm, drop then restore entry, reach deep
  task automatic rearm_enter(input string req);
    cfg_en = 0; step(1);
    cfg_en = 1; step(1);
    chk(req, warn_n, 0);
    step(2);
    chk(req, well_off_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    chk("R1 warn", warn_n, 1);
    chk("R1 well", well_off_n, 1);
    chk("R1 cause", wake_cause, 0);

    // R2/R3: exhaustive entry sweep, ack held high so the wells never drop
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      logic e;
      v = 13'(i);
      cfg_en = v[0]; mgmt_off = v[1]; sleep_st = v[3:2]; on_ac = v[4];
      pol_ok = v[8:5]; pol_need_bl = v[9]; batt_low = v[10];
      pol_need_conn = v[11]; conn_wake_en = v[12];
      e = v[0] & v[1] & v[3] & pol_ok[{v[2], v[4]}] & (~v[9] | v[10]) & (~v[11] | v[12]);
      step(1);
      if (v[9] | v[11]) chk("R3 entry", warn_n, int'(!e));
      else              chk("R2 entry", warn_n, int'(!e));
      cfg_en = 0;
      step(1);
      if (e) begin
        chk("R5 abort warn", warn_n, 1);
        chk("R5 abort well", well_off_n, 1);
      end
    end

    // R4: acknowledge filter
    good_setup(); ack_n = 1;
    step(5);
    chk("R4 warn held", warn_n, 0);
    chk("R4 no ack", well_off_n, 1);
    ack_n = 0; step(1);
    ack_n = 1; step(1);
    chk("R4 short ack", well_off_n, 1);
    ack_n = 0; step(1);
    chk("R4 one cycle", well_off_n, 1);
    step(1);
    chk("R4 filtered", well_off_n, 0);
    chk("R11 cleared", wake_cause, 0);

    // R7: disabled sources ignored
    wake_en = 0;
    for (int s = 0; s < 5; s++) begin
      if (s == 1) continue;
      wake_req = 5'(1) << s; step(1);
      wake_req = 0;          step(1);
      chk("R7 ignored", well_off_n, 0);
    end

    // R6/R11: RTC wake
    wake_en = 5'b00001; wake_req = 5'b00001; step(1);
    wake_req = 0;
    chk("R6 rtc wake", well_off_n, 1);
    chk("R11 warn still", warn_n, 0);
    chk("R11 cause rtc", wake_cause, 6'b000001);
    step(1);
    chk("R11 warn released", warn_n, 1);

    // R12: no re-entry while conditions stay true
    step(3);
    chk("R12 hold", warn_n, 1);
    rearm_enter("R12 rearm");
    chk("R11 cleared again", wake_cause, 0);

    // R6: button with no enable, plus enabled LAN
    wake_en = 5'b01000; wake_req = 5'b01010; step(1);
    wake_req = 0;
    chk("R6 button", well_off_n, 1);
    chk("R11 cause btn lan", wake_cause, 6'b001010);
    step(1);
    rearm_enter("R12 rearm2");

    // R8/R9: AC rise under battery-only policy
    wake_en = 0;
    on_ac = 1; step(1);
    chk("R8 ac up well", well_off_n, 1);
    chk("R8 ac up warn", warn_n, 0);
    step(2);
    chk("R8 ac up holds", well_off_n, 1);
    chk("R8 no cause", wake_cause, 0);
    on_ac = 0; step(1);
    chk("R9 reentry", well_off_n, 0);

    // R8: other policy ignores the AC rise
    pol_ok = 4'b1100; step(1);
    on_ac = 1; step(2);
    chk("R8 policy ignore", well_off_n, 0);
    on_ac = 0; pol_ok = 4'b0100; step(2);
    chk("R8 still deep", well_off_n, 0);

    // R10: AC rise as an enabled wake
    ac_wake_en = 1; on_ac = 1; step(1);
    chk("R10 ac wake", well_off_n, 1);
    chk("R10 cause", wake_cause, 6'b100000);
    step(1);
    chk("R10 warn released", warn_n, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule